// File: doc/BRIEF.md
# DDR2 Refresh and Self-Refresh Sequencer

This block keeps a DDR2 device refreshed and handles its low-power self-refresh state. An interval timer produces one tick per average refresh period. The period is long in standard-temperature mode and halved when the `temp_hi` input is set. Each tick adds one to a count of owed refreshes. While any refresh is owed, the block raises a request to the command arbiter. The arbiter may postpone the grant, and the owed count keeps growing while it waits. Once the count reaches a threshold, an urgent flag tells the arbiter that it may wait no longer.

When the grant arrives, the block takes the bus. It issues a precharge-all command and then a refresh command. It then keeps every other command off the bus for the refresh cycle time. A self-refresh request follows the same path, but with one difference: the entry command goes out in place of the refresh, and clock enable falls with it. Entry is not taken while refreshes are still owed. Those refreshes are paid off first.

Clock enable holds each new level for a minimum number of rising edges. After it rises again, two separate wake-up windows apply. Non-read commands are allowed after a short window. Reads are allowed only after a much longer one. All timings are whole clock counts, set by parameters.

Top module: `ddr_refresh_seq`

## Requirements
- R1: The owed count rises by one every `REFI_STD` clocks while `temp_hi`=0 and every `REFI_HOT` clocks while `temp_hi`=1. The first rise comes `REFI_STD` clocks after reset is released.
- R2: The time between two refresh commands, counting from the end of self-refresh, never exceeds `GAP_MAX` clocks, provided the arbiter grants promptly once `ref_urgent` is high.
- R3: `ref_req` is high in idle whenever the owed count is non-zero. Withholding the grant postpones refreshes without losing them. Each refresh command lowers the count by one.
- R4: `ref_urgent` is high exactly when the owed count is at least `URGENT_AT`.
- R5: `ref_req` stays high until a grant is seen. A grant while `ref_req` is low has no effect: no command is issued, and both permission outputs stay high.
- R6: A grant sampled on a rising edge together with `ref_req` produces a precharge-all command (`cmd`=1) in the next cycle. The refresh command (`cmd`=2) follows `RPA_CYC` cycles later. Each command is valid for one cycle, and `cmd`=0 means no command.
- R7: From the precharge-all cycle until `RFC_CYC` cycles after the refresh command, `rd_ok` and `oth_ok` are low and no command is issued. Both are high in the cycle `RFC_CYC` after the refresh command.
- R8: With `sr_req` high and no refresh owed, a grant produces precharge-all and then the self-refresh entry command (`cmd`=3) `RPA_CYC` cycles later, with `cke` low in that cycle. If refreshes are owed when the grant is taken, a normal refresh is done instead.
- R9: Clock enable stays low for at least `CKE_HOLD` cycles after entry, even if `sr_req` falls at once. It rises in the cycle after that hold ends, once `sr_req` is low.
- R10: After `cke` rises, `oth_ok` goes high `XSNR_CYC` cycles later and `rd_ok` goes high `XSRD_CYC` cycles later.
- R11: The interval timer is frozen and cleared from the self-refresh grant until the exit delay ends. The owed count stays zero throughout. The next tick comes a full interval after the return to idle.
- R12: Out of reset, `ref_req`, `ref_urgent` and `cmd_valid` are 0, `cke`, `rd_ok` and `oth_ok` are 1, and the owed count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_hi | input | 1 | Selects the halved refresh interval |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| grant | input | 1 | Arbiter hands the bus to this block |
| ref_req | output | 1 | Bus request to the arbiter |
| ref_urgent | output | 1 | Owed count has reached the urgent threshold |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd | output | 2 | 0 none, 1 precharge-all, 2 refresh, 3 self-refresh entry |
| cke | output | 1 | Clock enable to the device |
| rd_ok | output | 1 | The arbiter may issue reads |
| oth_ok | output | 1 | The arbiter may issue non-read commands |
| owed | output | OWED_W | Number of refreshes owed |

## Verification
The maximum-gap assertion assumes that the arbiter grants soon after `ref_urgent` rises. It also assumes that the timer does not run long enough for the owed count to saturate. The stimulus lets the count climb to the urgent threshold, then grants back to back until nothing is owed. The hold and exit checks assume that `sr_req` is changed only at falling clock edges and that no grant is offered during a sequence. The bench drives all inputs at falling edges and raises the grant only while idle.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2,
        CMD_SRE  = 2'd3
    } ref_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREA,
        ST_RP,
        ST_REF,
        ST_RFC,
        ST_SRE,
        ST_SR,
        ST_SRX
    } seq_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
    parameter int REFI_STD = 390,
    parameter int REFI_HOT = 195
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hot,
    output logic tick
);
    localparam int CW = $clog2(REFI_STD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = hot ? CW'(REFI_HOT - 1) : CW'(REFI_STD - 1);
    assign tick = en && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R1: the counter never runs past the longer interval
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(REFI_STD - 1));

endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
    parameter  int OWED_MAX  = 9,
    parameter  int URGENT_AT = 8,
    localparam int OW        = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] count,
    output logic          nonzero,
    output logic          urgent
);
    logic at_max;

    assign at_max  = (count == OW'(OWED_MAX));
    assign nonzero = (count != '0);
    assign urgent  = (count >= OW'(URGENT_AT));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({inc && !at_max, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a refresh is only ever paid against an owed one
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> nonzero);

    // R3: the count stays within its bound
    a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= OW'(OWED_MAX));

endmodule

// File: rtl/ref_seq_ctrl.sv
module ref_seq_ctrl
    import ddr_ref_pkg::*;
#(
    parameter int RPA_CYC  = 2,
    parameter int RFC_CYC  = 7,
    parameter int XSNR_CYC = 7,
    parameter int XSRD_CYC = 200,
    parameter int CKE_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       grant,
    input  logic       sr_req,
    input  logic       owed_nz,
    output logic       req,
    output logic       cmd_valid,
    output logic [1:0] cmd,
    output logic       cke,
    output logic       rd_ok,
    output logic       oth_ok,
    output logic       ref_done,
    output logic       sr_hold
);
    localparam int WMAX = max4(RPA_CYC, RFC_CYC, XSRD_CYC, CKE_HOLD);
    localparam int WW   = $clog2(WMAX + 1);

    seq_state_e    state;
    logic          goal_sr;
    logic [WW-1:0] wcnt;

    assign req      = (state == ST_IDLE) && (owed_nz || sr_req);
    assign ref_done = (state == ST_REF);
    assign sr_hold  = goal_sr;
    assign cke      = !((state == ST_SRE) || (state == ST_SR));
    assign rd_ok    = (state == ST_IDLE);
    assign oth_ok   = (state == ST_IDLE) ||
                      ((state == ST_SRX) && (wcnt >= WW'(XSNR_CYC)));

    always_comb begin
        cmd_valid = 1'b1;
        cmd       = CMD_NOP;
        unique case (state)
            ST_PREA: cmd = CMD_PREA;
            ST_REF:  cmd = CMD_REF;
            ST_SRE:  cmd = CMD_SRE;
            default: cmd_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            goal_sr <= 1'b0;
            wcnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req && grant) begin
                    state   <= ST_PREA;
                    goal_sr <= sr_req && !owed_nz;
                end
                ST_PREA: begin
                    wcnt  <= WW'(RPA_CYC - 2);
                    state <= ST_RP;
                end
                ST_RP: begin
                    if (wcnt == '0) state <= goal_sr ? ST_SRE : ST_REF;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_REF: begin
                    wcnt  <= WW'(RFC_CYC - 2);
                    state <= ST_RFC;
                end
                ST_RFC: begin
                    if (wcnt == '0) state <= ST_IDLE;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_SRE: begin
                    wcnt  <= WW'(CKE_HOLD - 2);
                    state <= ST_SR;
                end
                ST_SR: begin
                    if (wcnt != '0) wcnt <= wcnt - 1'b1;
                    else if (!sr_req) begin
                        wcnt  <= '0;
                        state <= ST_SRX;
                    end
                end
                ST_SRX: begin
                    if (wcnt == WW'(XSRD_CYC - 1)) begin
                        state   <= ST_IDLE;
                        goal_sr <= 1'b0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: an owed refresh keeps its request up until it is granted
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (req && !grant && owed_nz) |=> req);

    // R8: self-refresh entry only with nothing owed
    a_r8_sre_owed_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_SRE) |-> !owed_nz);

    // R10: reads never open before non-read commands
    a_r10_read_implies_other: assert property (@(posedge clk) disable iff (rst)
        rd_ok |-> oth_ok);

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
    import ddr_ref_pkg::*;
#(
    parameter  int REFI_STD  = 390,
    parameter  int REFI_HOT  = 195,
    parameter  int RPA_CYC   = 2,
    parameter  int RFC_CYC   = 7,
    parameter  int XSNR_CYC  = 7,
    parameter  int XSRD_CYC  = 200,
    parameter  int CKE_HOLD  = 3,
    parameter  int URGENT_AT = 8,
    parameter  int OWED_MAX  = 9,
    parameter  int GAP_MAX   = 3515,
    localparam int OWED_W    = $clog2(OWED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_hi,
    input  logic              sr_req,
    input  logic              grant,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              cmd_valid,
    output logic [1:0]        cmd,
    output logic              cke,
    output logic              rd_ok,
    output logic              oth_ok,
    output logic [OWED_W-1:0] owed
);
    logic tick;
    logic owed_nz;
    logic ref_done;
    logic sr_hold;

    ref_tick_gen #(
        .REFI_STD (REFI_STD),
        .REFI_HOT (REFI_HOT)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (!sr_hold),
        .hot  (temp_hi),
        .tick (tick)
    );

    ref_owed_ctr #(
        .OWED_MAX  (OWED_MAX),
        .URGENT_AT (URGENT_AT)
    ) u_owed (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (ref_done),
        .count   (owed),
        .nonzero (owed_nz),
        .urgent  (ref_urgent)
    );

    ref_seq_ctrl #(
        .RPA_CYC  (RPA_CYC),
        .RFC_CYC  (RFC_CYC),
        .XSNR_CYC (XSNR_CYC),
        .XSRD_CYC (XSRD_CYC),
        .CKE_HOLD (CKE_HOLD)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .sr_req    (sr_req),
        .owed_nz   (owed_nz),
        .req       (ref_req),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cke       (cke),
        .rd_ok     (rd_ok),
        .oth_ok    (oth_ok),
        .ref_done  (ref_done),
        .sr_hold   (sr_hold)
    );

    // Checker state for the timing assertions below
    localparam int GW = $clog2(GAP_MAX + 1);
    localparam int SW = $clog2(RFC_CYC + 1);
    localparam int KW = $clog2(CKE_HOLD + 1);

    logic [GW-1:0] gap_cnt;
    logic [SW-1:0] since_ref;
    logic [KW-1:0] cke_run;
    logic          cke_prev;
    logic          ref_seen;

    assign ref_seen = cmd_valid && (cmd == CMD_REF);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '0;
            since_ref <= SW'(RFC_CYC - 1);
            cke_run   <= KW'(CKE_HOLD - 1);
            cke_prev  <= 1'b1;
        end else begin
            if (ref_seen || !cke)               gap_cnt <= '0;
            else if (gap_cnt != GW'(GAP_MAX))   gap_cnt <= gap_cnt + 1'b1;

            if (ref_seen)                              since_ref <= '0;
            else if (since_ref != SW'(RFC_CYC - 1))    since_ref <= since_ref + 1'b1;

            cke_prev <= cke;
            if (cke != cke_prev)                       cke_run <= '0;
            else if (cke_run != KW'(CKE_HOLD - 1))     cke_run <= cke_run + 1'b1;
        end
    end

    // R2: the refresh gap stays below the hard limit
    a_r2_gap_limit: assert property (@(posedge clk) disable iff (rst)
        gap_cnt < GW'(GAP_MAX));

    // R7: nothing is issued or permitted inside the refresh cycle time
    a_r7_quiet_rfc: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || oth_ok) |-> (since_ref >= SW'(RFC_CYC - 1)));

    // R9: each clock-enable level was held long enough before it changes
    a_r9_cke_hold: assert property (@(posedge clk) disable iff (rst)
        (cke != cke_prev) |-> (cke_run >= KW'(CKE_HOLD - 1)));

endmodule

// File: tb/ddr_refresh_seq_tb.sv
module ddr_refresh_seq_tb;
    import ddr_ref_pkg::*;

    localparam int REFI_STD = 390;
    localparam int REFI_HOT = 195;
    localparam int RPA      = 2;
    localparam int RFC      = 7;
    localparam int XSNR     = 7;
    localparam int XSRD     = 200;
    localparam int CKEH     = 3;
    localparam int URG      = 8;
    localparam int OMAX     = 9;
    localparam int GAP_MAX  = 3515;
    localparam int OW       = $clog2(OMAX + 1);

    logic          clk = 1'b0;
    logic          rst, temp_hi, sr_req, grant;
    logic          ref_req, ref_urgent, cmd_valid, cke, rd_ok, oth_ok;
    logic [1:0]    cmd;
    logic [OW-1:0] owed;

    ddr_refresh_seq #(
        .REFI_STD (REFI_STD), .REFI_HOT (REFI_HOT), .RPA_CYC (RPA),
        .RFC_CYC (RFC), .XSNR_CYC (XSNR), .XSRD_CYC (XSRD),
        .CKE_HOLD (CKEH), .URGENT_AT (URG), .OWED_MAX (OMAX),
        .GAP_MAX (GAP_MAX)
    ) u_dut (
        .clk (clk), .rst (rst), .temp_hi (temp_hi), .sr_req (sr_req),
        .grant (grant), .ref_req (ref_req), .ref_urgent (ref_urgent),
        .cmd_valid (cmd_valid), .cmd (cmd), .cke (cke), .rd_ok (rd_ok),
        .oth_ok (oth_ok), .owed (owed)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors  = 0;
    int miscomp  = 0;
    int last_ref = 0;
    bit ended    = 1'b0;

    typedef struct {
        logic [1:0] cmd;
        int         at;
    } exp_t;

    exp_t expq[$];

    task automatic chk(input string rq, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Monitor: every presented command is popped against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst && cmd_valid) begin
            vectors++;
            if (expq.size() == 0) begin
                miscomp++;
                $display("FAIL R5 unexpected command: got %0d expected none (cycle %0d)", cmd, cyc);
            end else begin
                e = expq.pop_front();
                if (cmd !== e.cmd || cyc != e.at) begin
                    miscomp++;
                    $display("FAIL R6 command: got %0d at %0d expected %0d at %0d",
                             cmd, cyc, e.cmd, e.at);
                end
            end
            if (cmd == CMD_REF) begin
                chk("R2 refresh gap within limit", int'(cyc - last_ref <= GAP_MAX), 1);
                last_ref = cyc;
            end
        end
        if (!rst && !cke) last_ref = cyc;
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Driver: grant one refresh and queue the expected commands
    task automatic do_ref();
        int c;
        c = cyc;
        grant = 1'b1;
        expq.push_back('{CMD_PREA, c + 1});
        expq.push_back('{CMD_REF,  c + 1 + RPA});
        @(negedge clk);
        grant = 1'b0;
        chk("R7 rd_ok low at precharge", rd_ok, 0);
        wait_cyc(c + RPA + RFC);
        chk("R7 oth_ok low at last tRFC cycle", oth_ok, 0);
        @(negedge clk);
        chk("R7 oth_ok back after tRFC", oth_ok, 1);
        chk("R7 rd_ok back after tRFC", rd_ok, 1);
    endtask

    task automatic sr_grant(output int s);
        int c;
        c = cyc;
        grant = 1'b1;
        expq.push_back('{CMD_PREA, c + 1});
        expq.push_back('{CMD_SRE,  c + 1 + RPA});
        @(negedge clk);
        grant = 1'b0;
        s = c + 1 + RPA;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, s, x;
        rst = 1'b1; grant = 1'b0; sr_req = 1'b0; temp_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t0 = cyc;

        // R12 reset state
        chk("R12 ref_req", ref_req, 0);
        chk("R12 ref_urgent", ref_urgent, 0);
        chk("R12 cmd_valid", cmd_valid, 0);
        chk("R12 cke", cke, 1);
        chk("R12 rd_ok", rd_ok, 1);
        chk("R12 oth_ok", oth_ok, 1);
        chk("R12 owed", owed, 0);

        // R5 grant without request is ignored
        grant = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 no command on stray grant", cmd_valid, 0);
            chk("R5 oth_ok kept on stray grant", oth_ok, 1);
        end
        grant = 1'b0;

        // R1 standard interval from reset
        while (!ref_req) @(negedge clk);
        chk("R1 standard interval", cyc - t0, REFI_STD);
        chk("R3 owed after first tick", owed, 1);
        chk("R4 not urgent at one owed", ref_urgent, 0);

        // R3 postponement keeps counting
        t1 = cyc;
        while (owed != 2) @(negedge clk);
        chk("R3 postponed tick spacing", cyc - t1, REFI_STD);
        chk("R5 request held while ungranted", ref_req, 1);

        // R1 hot interval
        temp_hi = 1'b1;
        t1 = cyc;
        while (owed != 3) @(negedge clk);
        chk("R1 hot interval", cyc - t1, REFI_HOT);

        // R4 urgent threshold
        while (owed != URG - 1) @(negedge clk);
        chk("R4 not urgent below threshold", ref_urgent, 0);
        while (owed != URG) @(negedge clk);
        chk("R4 urgent at threshold", ref_urgent, 1);

        // R6/R3 pay off all owed refreshes
        while (ref_req) do_ref();
        chk("R3 owed cleared", owed, 0);
        chk("R4 urgent cleared", ref_urgent, 0);

        // R8 self-refresh refused while owed: refresh first
        while (!ref_req) @(negedge clk);
        sr_req = 1'b1;
        do_ref();
        chk("R8 owed zero after forced refresh", owed, 0);
        chk("R8 request kept for self-refresh", ref_req, 1);

        sr_grant(s);
        wait_cyc(s);
        chk("R8 cke low at entry", cke, 0);
        sr_req = 1'b0;
        @(negedge clk);
        chk("R9 cke held low 1", cke, 0);
        @(negedge clk);
        chk("R9 cke held low 2", cke, 0);
        @(negedge clk);
        chk("R9 cke rises after hold", cke, 1);
        x = s + CKEH;

        // R10 exit delays
        wait_cyc(x + XSNR - 1);
        chk("R10 oth_ok low before exit delay", oth_ok, 0);
        @(negedge clk);
        chk("R10 oth_ok after non-read delay", oth_ok, 1);
        chk("R10 rd_ok still low", rd_ok, 0);
        wait_cyc(x + XSRD - 1);
        chk("R10 rd_ok low before read delay", rd_ok, 0);
        @(negedge clk);
        chk("R10 rd_ok after read delay", rd_ok, 1);
        chk("R11 owed zero after exit", owed, 0);

        // R11 long self-refresh freezes the timer
        sr_req = 1'b1;
        sr_grant(s);
        wait_cyc(s + 1000);
        chk("R11 cke low in long self-refresh", cke, 0);
        chk("R11 owed frozen in self-refresh", owed, 0);
        sr_req = 1'b0;
        x = s + 1001;
        wait_cyc(x + XSRD);
        chk("R10 rd_ok after long exit", rd_ok, 1);
        wait_cyc(x + XSRD + REFI_HOT - 1);
        chk("R11 no request before full interval", ref_req, 0);
        @(negedge clk);
        chk("R11 request after full interval", ref_req, 1);
        do_ref();

        repeat (5) @(negedge clk);
        chk("R6 scoreboard drained", expq.size(), 0);
        finish_run();
    end

endmodule